// File: doc/BRIEF.md
# Processor-Side Device Port Handshake Controller

This block sits between a processor's command stage and a general-purpose external device port. It runs four kinds of operation. It can load an external register from write data. It can store an external register into a read-data holding register. It can set a function line in bank 2 or bank 3. It can test a sense line in bank 2 or bank 3. A 4-bit register field selects one of sixteen external devices or registers.

Each operation follows a fully interlocked four-phase exchange with a device that is asynchronous to the clock. The controller raises one request line. It waits for the device's ready signal, then raises transfer-complete. It waits for the device to withdraw ready, and only then ends the operation. The operation therefore takes as long as the device needs.

Every device response passes through a two-flop synchronizer before the controller acts on it. The busy and zero responses, and the input bus, are captured in the cycle in which transfer-complete first rises. An optional cycle timeout abandons an operation whose device never becomes ready.

Top module: `dev_port_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all six request lines and `dev_tcs` are low, `cmd_ready` is 1, `done` is 0 and `flag_b`, `flag_z`, `err_timeout`, `err_bank` and `rdata` are 0.
- R2: An accepted command raises exactly one request line from the cycle after acceptance until release, chosen as follows: op 0 gives `req_load`; op 1 gives `req_store`; op 2 with bank 2 or 3 gives `req_set2` or `req_set3`; op 3 with bank 2 or 3 gives `req_tst2` or `req_tst3`. `dev_addr` carries the 4-bit register field.
- R3: While a request is up, `dev_obus` is stable. It carries all 17 write-data bits for op 0, the low 16 write-data bits with bit 16 forced to 0 for ops 2 and 3, and zero for op 1.
- R4: `dev_tcs` is never high while the device has not yet raised ready. It rises only after synchronized ready has been seen, and it stays high until the device drops ready.
- R5: `done` is a one-cycle pulse issued only after the device has dropped ready. In the `done` cycle, every request line and `dev_tcs` is low. A device that holds ready for a long time delays `done` accordingly.
- R6: For op 1, `rdata` takes the 17-bit input bus value present when transfer-complete rises. Other operations leave `rdata` unchanged.
- R7: For op 2, `flag_b` is the busy response of the addressed bank (`dev_by2` for bank 2, `dev_by3` for bank 3). For op 3, `flag_z` is that bank's zero response (`dev_ze2` or `dev_ze3`). Both flags are cleared when any command is accepted.
- R8: Op 2 or op 3 with a bank value other than 2 or 3 raises no request line. `done` and `err_bank` rise together in the cycle after acceptance.
- R9: If synchronized ready stays low for `TIMEOUT_CYC` (default 32) cycles of request, the request is dropped without `dev_tcs`, and `done` and `err_timeout` rise together.
- R10: `cmd_ready` is low from acceptance until `done`. A `cmd_valid` presented in that time is ignored and starts no later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 load, 1 store, 2 set line, 3 test line |
| cmd_bank | input | 2 | Bank for set/test (2 or 3) |
| cmd_reg | input | 4 | External register / device select |
| cmd_wdata | input | 17 | Load data, or line address in bits 15:0 |
| cmd_ready | output | 1 | Controller idle, command accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 17 | Last stored input-bus value |
| flag_b | output | 1 | Busy response of last set-line op |
| flag_z | output | 1 | Zero response of last test-line op |
| err_timeout | output | 1 | Last operation timed out |
| err_bank | output | 1 | Last operation had an illegal bank |
| dev_addr | output | 4 | Register select to devices |
| dev_obus | output | 17 | Output bus |
| dev_ibus | input | 17 | Input bus |
| req_load | output | 1 | Load-output request |
| req_store | output | 1 | Store-input request |
| req_set2 | output | 1 | Set-line request, bank 2 |
| req_set3 | output | 1 | Set-line request, bank 3 |
| req_tst2 | output | 1 | Test-line request, bank 2 |
| req_tst3 | output | 1 | Test-line request, bank 3 |
| dev_tcs | output | 1 | Transfer-complete strobe |
| dev_rdy | input | 1 | Device ready (asynchronous) |
| dev_by2 | input | 1 | Busy response, bank 2 |
| dev_by3 | input | 1 | Busy response, bank 3 |
| dev_ze2 | input | 1 | Zero response, bank 2 |
| dev_ze3 | input | 1 | Zero response, bank 3 |

## Verification
A table of commands is walked through every op and both legal banks. Each entry uses a different device ready delay and release delay, so one run separates a wrong request line or bank decode from wrong bus contents. The bench device drives opposite values on the two banks' response lines, so a bank swap in flag sampling flips the result. Store entries bracketed by load entries show whether `rdata` is held or overwritten. Directed cases cover illegal banks, a device that never answers, a device that holds ready for a long time, and a command offered while the controller is busy.

// File: rtl/dpc_pkg.sv
// Package: shared encodings for the device port handshake controller.
// Assumes: opcode values are fixed by the command interface.
package dpc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SETLN = 2'd2,
        OP_TSTLN = 2'd3
    } dpc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } dpc_state_e;

    localparam int NUM_REQ = 6;
endpackage

// File: rtl/dpc_sync.sv
// Module: multi-stage synchronizer for asynchronous device responses.
// Assumes: each bit is an independent level; multi-bit coherence is the
// sender's job (it holds responses stable while ready is high).
module dpc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // first stage captures the raw asynchronous level
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // each further stage resolves metastability of the one before
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dpc_fsm.sv
// Module: four-phase handshake sequencer with optional ready timeout.
// Assumes: rdy_s is already synchronized; start and reject are mutually
// exclusive and only asserted while idle.
module dpc_fsm
    import dpc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       reject,
    input  logic       rdy_s,
    output dpc_state_e st,
    output logic       done_o,
    output logic       err_to_o,
    output logic       err_bk_o
);
    localparam int TO_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC + 1) : 1;

    logic [TO_W-1:0] cnt;
    logic            to_hit;

    generate
        if (TIMEOUT_CYC > 0) begin : g_timeout
            // abort once the request has waited the full window
            assign to_hit = (cnt == TO_W'(TIMEOUT_CYC - 1));
        end else begin : g_no_timeout
            // no timeout: wait for ready forever
            assign to_hit = 1'b0;
        end
    endgenerate

    // sequence request, transfer, release; raise completion and errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            done_o   <= 1'b0;
            err_to_o <= 1'b0;
            err_bk_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st       <= ST_REQ;
                        cnt      <= '0;
                        err_to_o <= 1'b0;
                        err_bk_o <= 1'b0;
                    end else if (reject) begin
                        done_o   <= 1'b1;
                        err_to_o <= 1'b0;
                        err_bk_o <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (rdy_s) begin
                        st <= ST_XFER;
                    end else if (to_hit) begin
                        st       <= ST_IDLE;
                        done_o   <= 1'b1;
                        err_to_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: st <= ST_REL;
                ST_REL: begin
                    if (!rdy_s) begin
                        st     <= ST_IDLE;
                        done_o <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dpc_lines.sv
// Module: command latch, request-line decode, output bus and result capture.
// Assumes: accept is a one-cycle pulse while idle; cap is high for exactly
// the first cycle of transfer-complete; the input bus is held by the device.
module dpc_lines
    import dpc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    localparam int BUS_W = DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [1:0]         cmd_op,
    input  logic               cmd_bank3,
    input  logic [ADDR_W-1:0]  cmd_reg,
    input  logic [BUS_W-1:0]   cmd_wdata,
    input  logic               busy,
    input  logic               cap,
    input  logic               by2_s,
    input  logic               by3_s,
    input  logic               ze2_s,
    input  logic               ze3_s,
    input  logic [BUS_W-1:0]   ibus,
    output logic [NUM_REQ-1:0] req,
    output logic [ADDR_W-1:0]  addr,
    output logic [BUS_W-1:0]   obus,
    output logic [BUS_W-1:0]   rdata,
    output logic               flag_b,
    output logic               flag_z
);
    dpc_op_e op_q;
    logic    bank3_q;

    // latch the command and prepare the output bus word on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            bank3_q <= 1'b0;
            addr    <= '0;
            obus    <= '0;
        end else if (accept) begin
            op_q    <= dpc_op_e'(cmd_op);
            bank3_q <= cmd_bank3;
            addr    <= cmd_reg;
            case (dpc_op_e'(cmd_op))
                OP_LOAD:  obus <= cmd_wdata;
                OP_STORE: obus <= '0;
                default:  obus <= {1'b0, cmd_wdata[DATA_W-1:0]};
            endcase
        end
    end

    // decode the single active request line from op and bank
    always_comb begin
        req = '0;
        if (busy) begin
            case (op_q)
                OP_LOAD:  req[0] = 1'b1;
                OP_STORE: req[1] = 1'b1;
                OP_SETLN: req[bank3_q ? 3 : 2] = 1'b1;
                OP_TSTLN: req[bank3_q ? 5 : 4] = 1'b1;
                default:  req = '0;
            endcase
        end
    end

    // clear flags on acceptance; sample responses at transfer-complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            flag_b <= 1'b0;
            flag_z <= 1'b0;
        end else if (accept) begin
            flag_b <= 1'b0;
            flag_z <= 1'b0;
        end else if (cap) begin
            case (op_q)
                OP_STORE: rdata  <= ibus;
                OP_SETLN: flag_b <= bank3_q ? by3_s : by2_s;
                OP_TSTLN: flag_z <= bank3_q ? ze3_s : ze2_s;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dev_port_ctrl.sv
// Module: top of the processor-side device port handshake controller.
// Assumes: device responses are asynchronous and are held stable by the
// device while ready is high; bank values 2 and 3 are the only legal ones
// for set-line and test-line operations.
module dev_port_ctrl
    import dpc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_bank,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W:0]   cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W:0]   rdata,
    output logic              flag_b,
    output logic              flag_z,
    output logic              err_timeout,
    output logic              err_bank,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W:0]   dev_obus,
    input  logic [DATA_W:0]   dev_ibus,
    output logic              req_load,
    output logic              req_store,
    output logic              req_set2,
    output logic              req_set3,
    output logic              req_tst2,
    output logic              req_tst3,
    output logic              dev_tcs,
    input  logic              dev_rdy,
    input  logic              dev_by2,
    input  logic              dev_by3,
    input  logic              dev_ze2,
    input  logic              dev_ze3
);
    localparam int RESP_W = 5;

    dpc_state_e         st;
    logic [RESP_W-1:0]  resp_s;
    logic [NUM_REQ-1:0] req;
    logic               accept, line_op, bank_bad, start, reject;

    // command acceptance and bank legality
    always_comb begin
        cmd_ready = (st == ST_IDLE);
        accept    = cmd_valid && cmd_ready;
        line_op   = (cmd_op == OP_SETLN) || (cmd_op == OP_TSTLN);
        bank_bad  = line_op && (cmd_bank[1] != 1'b1);
        start     = accept && !bank_bad;
        reject    = accept && bank_bad;
    end

    dpc_sync #(.WIDTH(RESP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dev_ze3, dev_ze2, dev_by3, dev_by2, dev_rdy}),
        .q     (resp_s)
    );

    dpc_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .reject   (reject),
        .rdy_s    (resp_s[0]),
        .st       (st),
        .done_o   (done),
        .err_to_o (err_timeout),
        .err_bk_o (err_bank)
    );

    dpc_lines #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cmd_op    (cmd_op),
        .cmd_bank3 (cmd_bank[0]),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .busy      (st != ST_IDLE),
        .cap       (st == ST_XFER),
        .by2_s     (resp_s[1]),
        .by3_s     (resp_s[2]),
        .ze2_s     (resp_s[3]),
        .ze3_s     (resp_s[4]),
        .ibus      (dev_ibus),
        .req       (req),
        .addr      (dev_addr),
        .obus      (dev_obus),
        .rdata     (rdata),
        .flag_b    (flag_b),
        .flag_z    (flag_z)
    );

    // fan the decoded request vector out to named lines and strobe
    always_comb begin
        {req_tst3, req_tst2, req_set3, req_set2, req_store, req_load} = req;
        dev_tcs = (st == ST_XFER) || (st == ST_REL);
    end
endmodule

// File: rtl/dev_port_ctrl_chk.sv
// Module: protocol checker for dev_port_ctrl, bound to every instance.
// Assumes: observes top-level ports only.
module dev_port_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              done,
    input logic              err_timeout,
    input logic              err_bank,
    input logic [DATA_W:0]   dev_obus,
    input logic              req_load,
    input logic              req_store,
    input logic              req_set2,
    input logic              req_set3,
    input logic              req_tst2,
    input logic              req_tst3,
    input logic              dev_tcs
);
    logic any_req;
    assign any_req = req_load | req_store | req_set2 | req_set3 | req_tst2 | req_tst3;

    a_r2_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_load, req_store, req_set2, req_set3, req_tst2, req_tst3}));

    a_r3_obus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && $past(any_req)) |-> $stable(dev_obus));

    a_r4_tcs_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tcs |-> any_req);

    a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dev_tcs && !any_req));

    a_r8_bank_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_bank) |-> (done && !any_req));

    a_r9_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> (done && !dev_tcs));

    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> !cmd_ready);
endmodule

bind dev_port_ctrl dev_port_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .done        (done),
    .err_timeout (err_timeout),
    .err_bank    (err_bank),
    .dev_obus    (dev_obus),
    .req_load    (req_load),
    .req_store   (req_store),
    .req_set2    (req_set2),
    .req_set3    (req_set3),
    .req_tst2    (req_tst2),
    .req_tst3    (req_tst3),
    .dev_tcs     (dev_tcs)
);

// File: tb/dev_port_ctrl_bench.sv
// Bench: vector table of commands against a behavioural device, then
// directed cases for reset, illegal bank, timeout, long release, busy.
module dev_port_ctrl_bench;
    localparam int TO = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0, cmd_bank = '0;
    logic [3:0]  cmd_reg = '0;
    logic [16:0] cmd_wdata = '0;
    logic        cmd_ready, done, flag_b, flag_z, err_timeout, err_bank;
    logic [16:0] rdata, dev_obus;
    logic [16:0] dev_ibus = '0;
    logic [3:0]  dev_addr;
    logic        req_load, req_store, req_set2, req_set3, req_tst2, req_tst3, dev_tcs;
    logic        dev_rdy = 1'b0, dev_by2 = 1'b0, dev_by3 = 1'b0, dev_ze2 = 1'b0, dev_ze3 = 1'b0;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dev_port_ctrl #(.TIMEOUT_CYC(TO)) u_dev_port_ctrl (.*);

    // behavioural device state
    int          dm_state = 0, dm_cnt = 0;
    int          rdy_dly = 0, rel_dly = 0;
    bit          no_resp = 0, tcs_early = 0, tcs_seen = 0;
    logic [16:0] v_ibus = '0, seen_obus = '0;
    logic        v_by = 0, v_ze = 0;
    logic [5:0]  seen = '0;
    logic [3:0]  seen_addr = '0;

    // device model: answer requests on falling edges
    always @(negedge clk) begin
        logic [5:0] rv;
        rv = {req_tst3, req_tst2, req_set3, req_set2, req_store, req_load};
        seen = seen | rv;
        case (dm_state)
            0: begin
                if (dev_tcs) tcs_early = 1;
                if (|rv) begin
                    seen_addr = dev_addr;
                    if (!no_resp) begin
                        if (dm_cnt >= rdy_dly) begin
                            dev_ibus = v_ibus;
                            dev_by2 = v_by;  dev_by3 = !v_by;
                            dev_ze2 = v_ze;  dev_ze3 = !v_ze;
                            dev_rdy = 1; dm_state = 1; dm_cnt = 0;
                        end else dm_cnt++;
                    end
                end
            end
            1: if (dev_tcs) begin seen_obus = dev_obus; tcs_seen = 1; dm_state = 2; end
            2: if (dm_cnt >= rel_dly) begin dev_rdy = 0; dm_state = 3; dm_cnt = 0; end
               else dm_cnt++;
            default: if (!(|rv)) begin dm_state = 0; dm_cnt = 0; end
        endcase
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    logic [16:0] exp_rdata = '0;

    // issue one command, wait for completion and check every result
    task automatic run_op(input logic [1:0] op, input logic [1:0] bank, input logic [3:0] rg,
                          input logic [16:0] wd, input logic [16:0] ib, input logic by,
                          input logic ze, input int rd, input int rl, input bit nr,
                          output int cyc);
        logic [5:0]  exp_line;
        logic [16:0] exp_obus;
        bit          badb;
        bit          got;
        badb = (op >= 2) && (bank[1] != 1'b1);
        case (op)
            2'd0: exp_line = 6'b000001;
            2'd1: exp_line = 6'b000010;
            2'd2: exp_line = bank[0] ? 6'b001000 : 6'b000100;
            default: exp_line = bank[0] ? 6'b100000 : 6'b010000;
        endcase
        if (badb) exp_line = '0;
        exp_obus = (op == 2'd0) ? wd : (op == 2'd1) ? 17'h0 : {1'b0, wd[15:0]};
        seen = '0; tcs_seen = 0; tcs_early = 0;
        v_ibus = ib; v_by = by; v_ze = ze; rdy_dly = rd; rel_dly = rl; no_resp = nr;
        @(negedge clk);
        cmd_op = op; cmd_bank = bank; cmd_reg = rg; cmd_wdata = wd; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        cyc = 1; got = 0;
        while (!got && cyc < 400) begin
            if (done) got = 1;
            else begin
                chk(!cmd_ready, "R10 cmd_ready low while busy", {31'b0, cmd_ready}, 0);
                @(negedge clk); cyc++;
            end
        end
        chk(got, "R5 done arrives", {31'b0, got}, 1);
        chk(seen == exp_line, "R2 request line", {26'b0, seen}, {26'b0, exp_line});
        chk(!dev_rdy && !dev_tcs && !(|{req_load, req_store, req_set2, req_set3, req_tst2, req_tst3}),
            "R5 quiet at done", {30'b0, dev_rdy, dev_tcs}, 0);
        chk(!tcs_early, "R4 no tcs before ready", {31'b0, tcs_early}, 0);
        chk(err_bank == badb, "R8 err_bank", {31'b0, err_bank}, {31'b0, badb});
        chk(err_timeout == nr, "R9 err_timeout", {31'b0, err_timeout}, {31'b0, nr});
        if (!badb) chk(seen_addr == rg, "R2 dev_addr", {28'b0, seen_addr}, {28'b0, rg});
        if (!badb && !nr) begin
            chk(seen_obus == exp_obus, "R3 output bus", {15'b0, seen_obus}, {15'b0, exp_obus});
            if (op == 2'd1) exp_rdata = ib;
        end
        if (nr) chk(!tcs_seen, "R9 no tcs on timeout", {31'b0, tcs_seen}, 0);
        chk(rdata == exp_rdata, "R6 rdata", {15'b0, rdata}, {15'b0, exp_rdata});
        chk(flag_b == (!badb && !nr && op == 2'd2 && (bank[0] ? !by : by)), "R7 flag_b",
            {31'b0, flag_b}, {31'b0, (!badb && !nr && op == 2'd2 && (bank[0] ? !by : by))});
        chk(flag_z == (!badb && !nr && op == 2'd3 && (bank[0] ? !ze : ze)), "R7 flag_z",
            {31'b0, flag_z}, {31'b0, (!badb && !nr && op == 2'd3 && (bank[0] ? !ze : ze))});
        @(negedge clk);
        chk(!done, "R5 done one cycle", {31'b0, done}, 0);
    endtask

    // fields: op[47:46] bank[45:44] reg[43:40] wdata[39:23] ibus[22:6] by[5] ze[4] rdly[3:0]
    localparam logic [47:0] VEC [8] = '{
        {2'd0, 2'd0, 4'd3,  17'h1A5A5, 17'h00000, 1'b0, 1'b0, 4'd1},
        {2'd1, 2'd0, 4'd15, 17'h00000, 17'h15A3C, 1'b0, 1'b0, 4'd3},
        {2'd2, 2'd2, 4'd0,  17'h0BEEF, 17'h00000, 1'b1, 1'b0, 4'd0},
        {2'd2, 2'd3, 4'd1,  17'h1C0DE, 17'h00000, 1'b1, 1'b0, 4'd2},
        {2'd3, 2'd2, 4'd2,  17'h00F0F, 17'h00000, 1'b0, 1'b1, 4'd5},
        {2'd3, 2'd3, 4'd7,  17'h13333, 17'h00000, 1'b0, 1'b0, 4'd1},
        {2'd1, 2'd1, 4'd8,  17'h00000, 17'h00001, 1'b0, 1'b0, 4'd0},
        {2'd0, 2'd3, 4'd12, 17'h10000, 17'h1FFFF, 1'b1, 1'b1, 4'd7}
    };

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready && !done && !dev_tcs &&
            !(|{req_load, req_store, req_set2, req_set3, req_tst2, req_tst3}),
            "R1 reset outputs", {30'b0, cmd_ready, done}, 32'h2);
        chk(!flag_b && !flag_z && !err_timeout && !err_bank && rdata == 0,
            "R1 reset results", {15'b0, rdata}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready && !done && !dev_tcs, "R1 first cycle after reset", {31'b0, cmd_ready}, 1);

        for (int i = 0; i < 8; i++) begin
            logic [47:0] v;
            v = VEC[i];
            run_op(v[47:46], v[45:44], v[43:40], v[39:23], v[22:6], v[5], v[4],
                   int'(v[3:0]), i, 0, cyc);
        end

        // R8: illegal banks for set and test
        run_op(2'd2, 2'd1, 4'd4, 17'h00055, 17'h0, 1'b1, 1'b1, 0, 0, 0, cyc);
        chk(cyc == 1, "R8 done in cycle after accept", cyc, 1);
        run_op(2'd3, 2'd0, 4'd5, 17'h000AA, 17'h0, 1'b1, 1'b1, 0, 0, 0, cyc);

        // R9: silent device times out
        run_op(2'd3, 2'd3, 4'd6, 17'h01234, 17'h0, 1'b0, 1'b1, 0, 0, 1, cyc);
        chk(cyc >= TO && cyc <= TO + 3, "R9 timeout window", cyc, TO);

        // R5: long-held ready delays completion
        run_op(2'd0, 2'd0, 4'd9, 17'h0ABCD, 17'h0, 1'b0, 1'b0, 2, 40, 0, cyc);
        chk(cyc > 40, "R5 waits for release", cyc, 41);

        // R10: a command offered while busy is ignored
        seen = '0; v_by = 0; rdy_dly = 6; rel_dly = 4; no_resp = 0; tcs_early = 0;
        @(negedge clk);
        cmd_op = 2'd0; cmd_bank = 2'd0; cmd_reg = 4'd10; cmd_wdata = 17'h00777; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        repeat (2) @(negedge clk);
        cmd_op = 2'd1; cmd_reg = 4'd11; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        begin
            int n = 0;
            while (!done && n < 200) begin @(negedge clk); n++; end
        end
        chk(seen == 6'b000001, "R10 only first op ran", {26'b0, seen}, 1);
        seen = '0;
        repeat (20) @(negedge clk);
        chk(seen == 6'b0 && !done, "R10 stray command ignored", {26'b0, seen}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule